// File: doc/BRIEF.md
# Gated Cross-Domain Frequency Counter

This block measures an asynchronous clock against the system clock. A start pulse in the system domain opens a gate. The gate lasts a fixed window of 2^TW − 1 system cycles. While the gate is open, a counter clocked by the measured clock counts that clock's cycles.

When the gate closes, the counter freezes and flips an acknowledge toggle. The system domain synchronizes that toggle and only then captures the frozen count. The count is shown on the result bus and a ready flag is raised. Dividing the result by the window length gives the ratio of the system period to the measured period.

The usual use is a monitor that checks a PLL or an external oscillator against a known reference.

Top module: `freq_gauge`

## Requirements
- R1: After an accepted start, the gate stays open for exactly 2^TW − 1 system clock cycles (15 cycles for TW = 4).
- R2: The result differs by at most one count from the ideal value (2^TW − 1) · Tsys / Tmeas.
- R3: The result width CW is independent of TW, so a measured clock faster than the system clock produces a result above 2^TW − 1 without truncation.
- R4: A high level on `start` at a system clock edge while `ready` is high, or while the block is idle, begins a measurement. `ready` is low right after that edge.
- R5: `ready` rises no earlier than 2^TW system cycles after the start edge. It rises no later than 2^TW − 1 + 6 + 3·⌈Tmeas/Tsys⌉ cycles after it.
- R6: Once high, `ready` stays high and `count` stays unchanged until the next start.
- R7: A start pulse during a measurement (gate open, or waiting for the result) is ignored. The window is neither restarted nor lengthened.
- R8: While `rst_n` is low, `ready` and `count` are 0 without waiting for a clock edge. After reset the block is idle.
- R9: The captured result equals the frozen measured-domain count, and that count is stable when captured. Repeated measurements of the same clock agree within the accuracy of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| clk_meas | input | 1 | Clock whose frequency is measured |
| start | input | 1 | Begins a measurement when the block is idle or holding a result |
| ready | output | 1 | High while a valid result is held |
| count | output | CW | Number of measured-clock cycles counted in the window |

## Verification
The hardest case to reach is a start pulse that arrives while the block is busy. It must be ignored both while the gate is open and while the system side waits for the acknowledge. The bench reaches this by pulsing start a few cycles into a window. It then checks that the latency and the count still match a single unextended window.

Accuracy depends on how the two clocks line up. The bench therefore sweeps the measured period over several values, both faster and slower than the reference, and computes each ideal ratio arithmetically.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GATE  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_HOLD  = 2'd3
  } fg_state_e;
endpackage

// File: rtl/fg_sync.sv
module fg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/fg_gate_ctrl.sv
module fg_gate_ctrl
  import fg_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack_evt,
  output logic gate_en,
  output logic capture,
  output logic ready
);
  localparam logic [TW-1:0] LAST = {{(TW-1){1'b1}}, 1'b0};

  fg_state_e       state_q, state_d;
  logic [TW-1:0]   timer_q, timer_d;

  always_comb begin
    state_d = state_q;
    timer_d = timer_q;
    case (state_q)
      ST_IDLE, ST_HOLD: begin
        if (start) begin
          state_d = ST_GATE;
          timer_d = '0;
        end
      end
      ST_GATE: begin
        if (timer_q == LAST) state_d = ST_DRAIN;
        else                 timer_d = timer_q + 1'b1;
      end
      ST_DRAIN: begin
        if (ack_evt) state_d = ST_HOLD;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      timer_q <= '0;
    end else begin
      state_q <= state_d;
      timer_q <= timer_d;
    end
  end

  assign gate_en = (state_q == ST_GATE);
  assign capture = (state_q == ST_DRAIN) && ack_evt;
  assign ready   = (state_q == ST_HOLD);
endmodule

// File: rtl/fg_edge_count.sv
module fg_edge_count #(
  parameter int CW = 20
) (
  input  logic          clk_meas,
  input  logic          rst_n,
  input  logic          gate_en,
  output logic [CW-1:0] cnt,
  output logic          done_tgl
);
  logic [1:0]    rs_q;
  logic          rst_m_n;
  logic          en_s;
  logic          en_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          tgl_q, tgl_d;

  always_ff @(posedge clk_meas or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_m_n = rs_q[1];

  fg_sync #(.STAGES(2)) u_en_sync (
    .clk   (clk_meas),
    .rst_n (rst_m_n),
    .d     (gate_en),
    .q     (en_s)
  );

  always_comb begin
    cnt_d = cnt_q;
    tgl_d = tgl_q;
    if (en_s && !en_q)      cnt_d = {{(CW-1){1'b0}}, 1'b1};
    else if (en_s)          cnt_d = cnt_q + 1'b1;
    if (!en_s && en_q)      tgl_d = ~tgl_q;
  end

  always_ff @(posedge clk_meas or negedge rst_m_n) begin
    if (!rst_m_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
      tgl_q <= 1'b0;
    end else begin
      en_q  <= en_s;
      cnt_q <= cnt_d;
      tgl_q <= tgl_d;
    end
  end

  assign cnt      = cnt_q;
  assign done_tgl = tgl_q;
endmodule

// File: rtl/freq_gauge.sv
module freq_gauge #(
  parameter int TW = 16,
  parameter int CW = 20
) (
  input  logic          clk_sys,
  input  logic          rst_n,
  input  logic          clk_meas,
  input  logic          start,
  output logic          ready,
  output logic [CW-1:0] count
);
  logic          gate_en;
  logic          capture;
  logic [CW-1:0] meas_cnt;
  logic          done_tgl;
  logic          ack_s;
  logic          ack_q;
  logic          ack_evt;
  logic [CW-1:0] count_q, count_d;

  fg_gate_ctrl #(.TW(TW)) u_ctrl (
    .clk     (clk_sys),
    .rst_n   (rst_n),
    .start   (start),
    .ack_evt (ack_evt),
    .gate_en (gate_en),
    .capture (capture),
    .ready   (ready)
  );

  fg_edge_count #(.CW(CW)) u_cnt (
    .clk_meas (clk_meas),
    .rst_n    (rst_n),
    .gate_en  (gate_en),
    .cnt      (meas_cnt),
    .done_tgl (done_tgl)
  );

  fg_sync #(.STAGES(2)) u_ack_sync (
    .clk   (clk_sys),
    .rst_n (rst_n),
    .d     (done_tgl),
    .q     (ack_s)
  );

  assign ack_evt = ack_s ^ ack_q;

  always_comb begin
    count_d = count_q;
    if (capture) count_d = meas_cnt;
  end

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      count_q <= '0;
    end else begin
      ack_q   <= ack_s;
      count_q <= count_d;
    end
  end

  assign count = count_q;
endmodule

// File: rtl/freq_gauge_chk.sv
module freq_gauge_chk #(
  parameter int TW = 16,
  parameter int CW = 20
) (
  input logic          clk_sys,
  input logic          rst_n,
  input logic          start,
  input logic          ready,
  input logic [CW-1:0] count,
  input logic          gate_en,
  input logic [CW-1:0] meas_cnt
);
  localparam logic [TW:0] WINDOW = {1'b0, {TW{1'b1}}};

  logic [TW:0] glen_q;

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n)       glen_q <= '0;
    else if (gate_en) glen_q <= glen_q + 1'b1;
    else              glen_q <= '0;
  end

  // R1
  gate_len_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
    $fell(gate_en) |-> glen_q == WINDOW);

  // R7
  gate_bound_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
    gate_en |-> glen_q < WINDOW);

  // R4
  start_clears_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
    ready && start |=> !ready);

  // R6
  hold_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
    ready && !start |=> ready && $stable(count));

  // R9
  capture_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
    $rose(ready) |-> count == $past(meas_cnt));

  // R9
  frozen_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
    $rose(ready) |-> $past(meas_cnt) == $past(meas_cnt, 2));
endmodule

bind freq_gauge freq_gauge_chk #(.TW(TW), .CW(CW)) u_chk (
  .clk_sys  (clk_sys),
  .rst_n    (rst_n),
  .start    (start),
  .ready    (ready),
  .count    (count),
  .gate_en  (gate_en),
  .meas_cnt (meas_cnt)
);

// File: tb/freq_gauge_bench.sv
`timescale 1ns/1ps
module freq_gauge_bench;
  localparam int  TW     = 4;
  localparam int  CW     = 8;
  localparam int  WINDOW = (1 << TW) - 1;
  localparam real TSYS   = 5.0;

  logic          clk_sys;
  logic          clk_meas;
  logic          rst_n;
  logic          start;
  logic          ready;
  logic [CW-1:0] count;

  int  n_checks;
  int  n_fail;
  real meas_half;
  bit  done;

  freq_gauge #(.TW(TW), .CW(CW)) u_freq_gauge (
    .clk_sys  (clk_sys),
    .rst_n    (rst_n),
    .clk_meas (clk_meas),
    .start    (start),
    .ready    (ready),
    .count    (count)
  );

  initial clk_sys = 1'b0;
  always #(TSYS / 2.0) clk_sys = ~clk_sys;

  initial begin
    clk_meas  = 1'b0;
    meas_half = 2.18;
  end
  always #(meas_half) clk_meas = ~clk_meas;

  task automatic check(input bit ok, input string tag, input int act, input int exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  // one measurement: pulse start, optionally pulse it again while busy
  task automatic measure(input int busy_poke, output int cnt, output int lat);
    @(negedge clk_sys) start = 1'b1;
    @(negedge clk_sys) start = 1'b0;
    check(ready == 1'b0, "R4 ready low after start", int'(ready), 0);
    lat = 1;
    while (!ready && lat < 400) begin
      @(negedge clk_sys);
      lat++;
      if (busy_poke != 0 && lat == busy_poke) start = 1'b1;
      else                                    start = 1'b0;
    end
    start = 1'b0;
    cnt = int'(count);
  endtask

  task automatic judge(input real tm, input int cnt, input int lat, input string tag);
    real ideal;
    real diff;
    int  hi;
    ideal = real'(WINDOW) * TSYS / tm;
    diff  = real'(cnt) - ideal;
    if (diff < 0.0) diff = -diff;
    hi = WINDOW + 6 + 3 * int'($ceil(tm / TSYS));
    check(diff <= 1.0, {tag, " R2 count within one of ideal"}, cnt, int'(ideal));
    check(lat >= WINDOW + 1 && lat <= hi, {tag, " R5 ready latency"}, lat, hi);
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    start    = 1'b0;
    rst_n    = 1'b0;
    repeat (4) @(negedge clk_sys);
    // R8 reset state
    check(ready == 1'b0, "R8 ready in reset", int'(ready), 0);
    check(count == '0,  "R8 count in reset", int'(count), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk_sys);
    check(ready == 1'b0, "R8 idle after reset", int'(ready), 0);

    // sweep of measured periods, slower and faster than the reference
    for (int i = 0; i < 8; i++) begin
      real tm;
      int  c;
      int  l;
      int  c2;
      int  l2;
      tm = 1.9 + 1.37 * real'(i);
      meas_half = tm / 2.0;
      repeat (3 + i) @(negedge clk_sys);
      measure(0, c, l);
      judge(tm, c, l, "sweep");
      if (tm < TSYS)
        check(c > WINDOW, "R3 count exceeds window length", c, WINDOW + 1);
      // R6 result held without a new start
      repeat (20) @(negedge clk_sys);
      check(ready == 1'b1 && int'(count) == c, "R6 result held", int'(count), c);
      // R9 repeat measurement agrees
      measure(0, c2, l2);
      check(c2 - c <= 1 && c - c2 <= 1, "R9 repeat agrees", c2, c);
    end

    // R7 start during gate and during the drain phase is ignored
    for (int k = 0; k < 2; k++) begin
      real tm;
      int  c;
      int  l;
      tm = (k == 0) ? 2.63 : 9.1;
      meas_half = tm / 2.0;
      repeat (5) @(negedge clk_sys);
      measure((k == 0) ? 6 : WINDOW + 2, c, l);
      judge(tm, c, l, "R7 busy start");
    end

    // R8 asynchronous reset in the middle of a measurement
    @(negedge clk_sys) start = 1'b1;
    @(negedge clk_sys) start = 1'b0;
    repeat (5) @(negedge clk_sys);
    #1 rst_n = 1'b0;
    #0.5;
    check(ready == 1'b0 && count == '0, "R8 async reset clears", int'(count), 0);
    repeat (3) @(negedge clk_sys);
    rst_n = 1'b1;
    repeat (40) @(negedge clk_sys);
    check(ready == 1'b0, "R8 idle after mid-run reset", int'(ready), 0);

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk_sys);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule